// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block lets a clocked host read and write an asynchronous static RAM module. The module is 32 bits wide and 262,144 words deep, and each of its four byte lanes has its own active-low select. The host side uses a request/ready handshake. The host presents an 18-bit word address, 32-bit write data, a 4-bit byte enable and a read/write flag. The block answers with 32-bit read data and a one-clock valid strobe. On the memory side the block drives the address, the four lane selects, active-low write and output strobes, and a shared tri-state data bus.

Writes are controlled by the write strobe. The controller first applies address and lane selects and waits a setup count. It then lowers the write strobe. It starts driving the bus one clock after the strobe falls, because the memory stops driving its pins only while the strobe is low. The strobe rises while the data is still driven, and the bus is released one clock later. Reads hold the output strobe low for an access count and capture the bus on the closing edge. Every read ends with a clock in which the output strobe and all selects are high. This turnaround clock keeps the memory's drivers and the controller's drivers off the bus at the same time. All wait counts are parameters.

The controller is built around one state machine with these states:
- `ST_IDLE`: ready.
- `ST_WR_SETUP`: address and selects applied, write strobe high.
- `ST_WR_STROBE`: write strobe low, bus not yet driven.
- `ST_WR_DRIVE`: write strobe low, bus driven.
- `ST_WR_HOLD`: write strobe high, bus still driven.
- `ST_RD_ACCESS`: output strobe low.
- `ST_RD_TURN`: turnaround clock, valid strobe high.

Its transitions:
- `ST_IDLE` to `ST_WR_SETUP` on an accepted write.
- `ST_IDLE` to `ST_RD_ACCESS` on an accepted read.
- `ST_IDLE` to `ST_IDLE` on an accepted request with no byte enabled.
- `ST_WR_SETUP` to `ST_WR_STROBE` when the setup count expires.
- `ST_WR_STROBE` to `ST_WR_DRIVE` always.
- `ST_WR_DRIVE` to `ST_WR_HOLD` when the pulse count expires.
- `ST_WR_HOLD` to `ST_IDLE` always.
- `ST_RD_ACCESS` to `ST_RD_TURN` when the access count expires; the bus is captured on this transition.
- `ST_RD_TURN` to `ST_IDLE` always.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset (asynchronous, active low), the outputs are idle: ready is high, all four lane selects are high, the write and output strobes are high, and the read valid strobe is low. A reset in the middle of a write returns all memory strobes high at once.
- R2: A request is taken only on a clock edge where both request and ready are high. Ready then stays low for the whole memory cycle. After acceptance, a write keeps ready low for SETUP_CYC+PULSE_CYC+2 clocks and a read keeps it low for ACCESS_CYC+1 clocks.
- R3: Lane select bit i (active low) is asserted only when byte enable bit i is 1. Bit i maps to data bits 8i+7..8i. Memory bytes whose enable is 0 keep their old contents after a write.
- R4: In a write, the write strobe is low for exactly PULSE_CYC+1 clocks and only while at least one lane select is low. The bus is still driven on the clock in which the write strobe rises.
- R5: The controller never drives the data bus while the output strobe is low. It starts driving only after the write strobe has been low for one clock.
- R6: The memory address equals the accepted host address and does not change from acceptance until ready returns.
- R7: A read holds the output strobe low for ACCESS_CYC clocks and captures the bus on the edge that ends that window. The valid strobe is then high for exactly one clock. Bytes whose enable is 0 read as zero.
- R8: On the clock after the output strobe was last low, the output strobe and all lane selects are high.
- R9: An accepted request with byte enable 0000 produces no memory strobes, leaves memory unchanged and leaves ready high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host request |
| host_rdy | output | 1 | Controller can accept a request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables, bit i for data bits 8i+7..8i |
| host_rdata | output | 32 | Captured read data |
| host_rvalid | output | 1 | Read data valid, one clock |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 4 | Lane selects, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq | inout | 32 | Shared data bus |

## Verification
The main function is tried in four ways, each against a byte-masked memory model:
- Full-word writes followed by reads show that data moves through the bus intact and that the model's address decode is reached.
- Single-lane and alternating-lane write masks show whether each select really isolates its byte, since the neighbouring bytes must survive.
- Partial-enable reads separate capture masking from lane selection: disabled lanes must come back as zero even though the memory holds data there.
- Zero-enable requests, and a reset in the middle of a write, show that strobes appear only for real accesses. Latency counts and write-pulse widths tell apart wrong wait-state sequencing that would still return correct data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_DRIVE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_TURN
    } ctrl_state_e;

endpackage

// File: rtl/asram_wait_cnt.sv
// Down counter for wait states: loaded with N-1, reports zero after N clocks.
module asram_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_sel.sv
// Per-lane active-low select generation.
module asram_lane_sel #(
    parameter int LANES = 4
) (
    input  logic             active,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] cs_n
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cs_n[g] = !(active && be[g]);
    end
endmodule

// File: rtl/asram_rd_capture.sv
// Read capture register; disabled lanes are stored as zero.
module asram_rd_capture #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LANES-1:0]   be,
    input  logic [8*LANES-1:0] bus_in,
    output logic [8*LANES-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rdata[8*g +: 8] <= '0;
            else if (capture)
                rdata[8*g +: 8] <= be[g] ? bus_in[8*g +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 32,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int ACCESS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    output logic              host_rdy,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W/8-1:0] host_be,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int LANES    = DATA_W / 8;
    localparam int MAX_A    = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_WAIT = (MAX_A > ACCESS_CYC) ? MAX_A : ACCESS_CYC;
    localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;

    ctrl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              accept;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic              cs_active;
    logic              drive_en;
    logic              capture;

    assign accept = host_req && host_rdy;

    // Request registers: loaded only at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            be_q    <= host_be;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and wait-count loads.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && host_be != '0) begin
                    cnt_load = 1'b1;
                    if (host_we) begin
                        state_d = ST_WR_SETUP;
                        cnt_val = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        state_d = ST_RD_ACCESS;
                        cnt_val = CNT_W'(ACCESS_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP:  if (cnt_zero) state_d = ST_WR_STROBE;
            ST_WR_STROBE: begin
                state_d  = ST_WR_DRIVE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(PULSE_CYC - 1);
            end
            ST_WR_DRIVE:  if (cnt_zero) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   state_d = ST_IDLE;
            ST_RD_ACCESS: if (cnt_zero) state_d = ST_RD_TURN;
            ST_RD_TURN:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        host_rdy    = (state_q == ST_IDLE);
        host_rvalid = (state_q == ST_RD_TURN);
        cs_active   = (state_q == ST_WR_SETUP) || (state_q == ST_WR_STROBE) ||
                      (state_q == ST_WR_DRIVE) || (state_q == ST_WR_HOLD)   ||
                      (state_q == ST_RD_ACCESS);
        mem_we_n    = !((state_q == ST_WR_STROBE) || (state_q == ST_WR_DRIVE));
        mem_oe_n    = (state_q != ST_RD_ACCESS);
        drive_en    = (state_q == ST_WR_DRIVE) || (state_q == ST_WR_HOLD);
        capture     = (state_q == ST_RD_ACCESS) && cnt_zero;
    end

    assign mem_addr = addr_q;
    assign mem_dq   = drive_en ? wdata_q : {DATA_W{1'bz}};

    asram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    asram_lane_sel #(.LANES(LANES)) u_sel (
        .active (cs_active),
        .be     (be_q),
        .cs_n   (mem_cs_n)
    );

    asram_rd_capture #(.LANES(LANES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .be      (be_q),
        .bus_in  (mem_dq),
        .rdata   (host_rdata)
    );

    // Write strobe only together with some lane select.
    assert_we_with_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_cs_n != '1));

    // Data still driven on the clock the write strobe rises.
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> drive_en);

    // No bus drive while the memory may drive.
    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> mem_oe_n);

    // Drive starts only after the strobe has been low one clock.
    assert_drive_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> $past(!mem_we_n));

    // Address held while busy.
    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rdy && !$rose(!host_rdy)) |-> $stable(mem_addr));

    // Valid strobe lasts one clock.
    assert_rvalid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // Turnaround clock after the output strobe.
    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_cs_n == '1));

    // Empty request makes no strobes.
    assert_zero_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && host_be == '0) |=> (host_rdy && mem_cs_n == '1 && mem_we_n));

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;
    localparam int SETUP_CYC  = 1;
    localparam int PULSE_CYC  = 2;
    localparam int ACCESS_CYC = 3;
    localparam int WR_CYC     = SETUP_CYC + PULSE_CYC + 3;
    localparam int RD_CYC     = ACCESS_CYC + 2;
    localparam int NVEC       = 11;

    // {we, be[3:0], addr[7:0], wdata[31:0], expected[31:0]}
    localparam logic [76:0] VEC [NVEC] = '{
        {1'b1, 4'hF, 8'h01, 32'h11223344, 32'h0},
        {1'b1, 4'hF, 8'h02, 32'hA5A5A5A5, 32'h0},
        {1'b0, 4'hF, 8'h01, 32'h0,        32'h11223344},
        {1'b1, 4'h1, 8'h01, 32'h998877EE, 32'h0},
        {1'b0, 4'hF, 8'h01, 32'h0,        32'h112233EE},
        {1'b1, 4'hA, 8'h02, 32'h77FF66FF, 32'h0},
        {1'b0, 4'hF, 8'h02, 32'h0,        32'h77A566A5},
        {1'b0, 4'h6, 8'h02, 32'h0,        32'h00A56600},
        {1'b0, 4'h9, 8'h01, 32'h0,        32'h110000EE},
        {1'b1, 4'h0, 8'h01, 32'hDEADBEEF, 32'h0},
        {1'b0, 4'hF, 8'h01, 32'h0,        32'h112233EE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [17:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_rdy, host_rvalid;
    logic [31:0] host_rdata;
    logic [17:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n, mem_oe_n;
    wire  [31:0] mem_dq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    asram_ctrl #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .ACCESS_CYC(ACCESS_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rdy(host_rdy),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_be(host_be), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );

    // Behavioural byte-masked memory model.
    logic [31:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 32'h0;

    always @(posedge mem_we_n) begin
        if (rst_n) begin
            for (int l = 0; l < 4; l++)
                if (mem_cs_n[l] == 1'b0) mem[mem_addr[7:0]][8*l +: 8] <= mem_dq[8*l +: 8];
        end
    end

    for (genvar l = 0; l < 4; l++) begin : g_model
        assign mem_dq[8*l +: 8] = (!mem_cs_n[l] && mem_we_n && !mem_oe_n) ?
                                  mem[mem_addr[7:0]][8*l +: 8] : 8'hzz;
    end

    // Port monitors, sampled on the falling edge.
    int   we_run = 0, last_pulse = 0, rvalid_cnt = 0;
    int   overlap_err = 0, turn_err = 0, addr_err = 0;
    logic prev_oe_n = 1'b1, prev_rdy = 1'b1;
    logic [17:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin last_pulse = we_run; we_run = 0; end
            if (!mem_oe_n && !mem_we_n) overlap_err++;
            if (!prev_oe_n && mem_oe_n && mem_cs_n != 4'hF) turn_err++;
            if (!prev_rdy && !host_rdy && mem_addr != prev_addr) addr_err++;
            if (host_rvalid) rvalid_cnt++;
        end
        prev_oe_n = mem_oe_n;
        prev_rdy  = host_rdy;
        prev_addr = mem_addr;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic txn(input bit we, input logic [3:0] be, input logic [7:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_be = be;
        host_addr = {10'h155, a}; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_wdata = 32'h0; host_be = 4'h0;
        cyc = 1; rd = 32'hxxxxxxxx;
        while (!host_rdy) begin
            @(negedge clk);
            cyc++;
            if (host_rvalid) rd = host_rdata;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        int reads;
        reads = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(host_rdy == 1'b1 && host_rvalid == 1'b0, "R1 rdy/rvalid", {host_rdy, host_rvalid}, 2'b10);
        chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n, "R1 strobes", {mem_cs_n, mem_we_n, mem_oe_n}, 6'h3F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [76:0] v;
            v = VEC[i];
            txn(v[76], v[75:72], v[71:64], v[63:32], rd, cyc);
            if (v[75:72] == 4'h0) begin
                chk(cyc == 1, "R9 zero-be latency", cyc, 1);
            end else if (v[76]) begin
                chk(cyc == WR_CYC, "R2 write latency", cyc, WR_CYC);
                chk(last_pulse == PULSE_CYC + 1, "R4 write pulse", last_pulse, PULSE_CYC + 1);
            end else begin
                reads++;
                chk(cyc == RD_CYC, "R2 read latency", cyc, RD_CYC);
                chk(rd === v[31:0], (v[75:72] == 4'hF) ? "R7 read data" : "R3 R7 lane mask",
                    rd, v[31:0]);
            end
        end

        // R9: strobes stay off on an empty request
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_be = 4'h0; host_addr = 18'h00001;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_rdy && mem_cs_n == 4'hF && mem_we_n, "R9 no strobes",
            {host_rdy, mem_cs_n, mem_we_n}, 6'h3F);
        chk(mem[1] == 32'h112233EE, "R9 memory unchanged", mem[1], 32'h112233EE);

        // R1: reset in the middle of a write
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_be = 4'hF; host_addr = 18'h00040; host_wdata = 32'h5A5A5A5A;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        chk(!mem_we_n, "R4 strobe low mid-write", mem_we_n, 0);
        rst_n = 1'b0;
        #0.5;
        chk(mem_we_n && mem_cs_n == 4'hF && host_rdy, "R1 mid-write reset",
            {mem_we_n, mem_cs_n, host_rdy}, 6'h3F);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Monitors
        chk(rvalid_cnt == reads, "R7 valid pulse count", rvalid_cnt, reads);
        chk(overlap_err == 0, "R5 output/write overlap", overlap_err, 0);
        chk(turn_err == 0, "R8 turnaround", turn_err, 0);
        chk(addr_err == 0, "R6 address stable", addr_err, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule